// File: doc/BRIEF.md
# Stall-Based Register Hazard Interlock Pipeline

This block is a five-stage in-order pipeline: fetch, decode, execute, memory and writeback. It has no bypass network. It protects read-after-write dependences through the register file by stalling. Each cycle the decode stage compares the operand registers that its instruction actually reads against the destination registers of the two older instructions in execute and memory. On a hit, the program counter and the fetch/decode latch hold, and an empty slot is inserted into the decode/execute latch. The slot's register-write and memory-write enables are cleared.

Control is decoded once, in decode. Afterwards only the part each later stage still needs travels with the instruction. The register file writes before it reads within a cycle, so a producer in writeback never stalls its consumer. Memory-to-memory dependences need no interlock, because loads and stores access data memory in the same stage. Instruction and data memories lie outside the block. The execute stage contains only the adder needed to form results and addresses.

Instruction word: opcode in bits 31:28, rd in 27:24, rs in 23:20, rt in 19:16, and a signed immediate in 15:0. The opcodes are:
- 0: no operation
- 1: add, rd = rs + rt
- 2: add immediate, rd = rs + imm
- 3: load, rd = mem[rs + imm]
- 4: store, mem[rs + imm] = rt

Top module: `raw_interlock_pipe`

## Requirements
- R1: While reset is held, `imem_addr` is 0 and `stall`, `wb_valid` and `dmem_we` are 0.
- R2: If the producer of a read operand is one instruction ahead, so that it is in execute, decode stalls for exactly 2 cycles.
- R3: If the producer of a read operand is two instructions ahead, so that it is in memory, decode stalls for exactly 1 cycle.
- R4: A producer in writeback causes no stall, and the consumer reads the newly written value in that same cycle.
- R5: A write to register 0 is dropped and never produces a `wb_valid` pulse. Reading register 0 returns 0 and never stalls.
- R6: Only operands that the opcode reads are compared. Add immediate and load ignore the rt field. Add and store compare both rs and rt.
- R7: During a stall cycle the fetch address holds. The inserted empty slot produces no register write and no memory write.
- R8: A load that directly follows a store to the same address returns the stored data, with no stall.
- R9: Results written back match in-order sequential execution of the program.
- R10: When both operands conflict, the stall lasts the longer of the two required delays. No stall runs longer than 2 consecutive cycles.
- R11: An instruction that leaves decode at cycle d raises `dmem_we` in cycle d+2 when it is a store. It shows its `wb_valid` result in cycle d+3 when it writes a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | PC_W | Word address of the instruction being fetched |
| imem_data | input | 32 | Instruction word at `imem_addr`, combinational |
| dmem_addr | output | XLEN | Data memory word address |
| dmem_wdata | output | XLEN | Store data |
| dmem_we | output | 1 | Store strobe, written at the clock edge |
| dmem_rdata | input | XLEN | Load data at `dmem_addr`, combinational |
| wb_valid | output | 1 | A register write happens this cycle |
| wb_dest | output | 4 | Destination register of the write |
| wb_data | output | XLEN | Value being written |
| stall | output | 1 | Decode is held this cycle |

## Verification
The bench builds a schedule from the program. Each instruction's decode-exit cycle is the later of two values: one past its predecessor's exit, or three past the exit of the last writer of any operand it reads. From that schedule it derives the expected `stall` cycles, the store strobe two cycles after exit, and the writeback three cycles after exit. Cycles are counted from the first edge after reset release. Outputs are compared in every cycle, sampled on the falling edge that follows each rising edge, so each registered result is read in the cycle it is due. Total bubble count and the register state rebuilt from writebacks are then compared against a sequential model of the program.

// File: rtl/rip_pkg.sv
// Shared types for the interlocked pipeline.
// Assumes a 32-bit instruction word with fixed field positions.
package rip_pkg;
    localparam int INSN_W = 32;
    localparam int OP_W   = 4;
    localparam int RA_W   = 4;
    localparam int IMM_W  = 16;
    localparam int NREG   = 1 << RA_W;

    localparam int OP_LSB  = INSN_W - OP_W;
    localparam int RD_LSB  = OP_LSB - RA_W;
    localparam int RS_LSB  = RD_LSB - RA_W;
    localparam int RT_LSB  = RS_LSB - RA_W;

    typedef enum logic [OP_W-1:0] {
        OPC_NOP  = 4'd0,
        OPC_ADD  = 4'd1,
        OPC_ADDI = 4'd2,
        OPC_LOAD = 4'd3,
        OPC_STOR = 4'd4
    } opcode_e;

    // Control needed only by execute
    typedef struct packed {
        logic use_imm;
    } ex_ctl_t;

    // Control needed by memory
    typedef struct packed {
        logic rd_en;
        logic wr_en;
    } mem_ctl_t;

    // Control needed by writeback
    typedef struct packed {
        logic rf_we;
    } wb_ctl_t;

    // Full decode result
    typedef struct packed {
        ex_ctl_t            ex;
        mem_ctl_t           mem;
        wb_ctl_t            wb;
        logic               rs_used;
        logic               rt_used;
        logic [RA_W-1:0]    rd;
        logic [RA_W-1:0]    rs;
        logic [RA_W-1:0]    rt;
        logic [IMM_W-1:0]   imm;
    } dec_t;
endpackage

// File: rtl/rip_decode.sv
// Instruction decoder: splits fields and produces the staged control bundle.
// Assumes unknown opcodes behave as no-operation; writes to register 0 are
// suppressed here so no later stage sees them as producers.
module rip_decode
    import rip_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output dec_t              dec
);
    opcode_e op;

    // Field extraction and per-opcode control
    always_comb begin
        op  = opcode_e'(insn[OP_LSB +: OP_W]);
        dec = '0;
        dec.rd  = insn[RD_LSB +: RA_W];
        dec.rs  = insn[RS_LSB +: RA_W];
        dec.rt  = insn[RT_LSB +: RA_W];
        dec.imm = insn[IMM_W-1:0];
        unique case (op)
            OPC_ADD: begin
                dec.rs_used  = 1'b1;
                dec.rt_used  = 1'b1;
                dec.wb.rf_we = (dec.rd != '0);
            end
            OPC_ADDI: begin
                dec.rs_used    = 1'b1;
                dec.ex.use_imm = 1'b1;
                dec.wb.rf_we   = (dec.rd != '0);
            end
            OPC_LOAD: begin
                dec.rs_used    = 1'b1;
                dec.ex.use_imm = 1'b1;
                dec.mem.rd_en  = 1'b1;
                dec.wb.rf_we   = (dec.rd != '0);
            end
            OPC_STOR: begin
                dec.rs_used    = 1'b1;
                dec.rt_used    = 1'b1;
                dec.ex.use_imm = 1'b1;
                dec.mem.wr_en  = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rip_hazard.sv
// Read-after-write comparator matrix.
// Each read operand of decode is compared with every in-flight producer
// that has not yet reached writeback. Register 0 never matches.
module rip_hazard
    import rip_pkg::*;
#(
    parameter int NSRC  = 2,
    parameter int NPROD = 2
) (
    input  logic [RA_W-1:0] src_idx  [NSRC],
    input  logic            src_used [NSRC],
    input  logic [RA_W-1:0] prod_idx [NPROD],
    input  logic            prod_we  [NPROD],
    output logic            stall
);
    localparam int NPAIR = NSRC * NPROD;

    logic [NPAIR-1:0] hit;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        for (genvar p = 0; p < NPROD; p++) begin : g_prod
            // One comparator per operand/producer pair
            assign hit[s*NPROD + p] = src_used[s] && prod_we[p]
                                    && (src_idx[s] != '0)
                                    && (src_idx[s] == prod_idx[p]);
        end
    end

    // Any pair match holds decode
    assign stall = |hit;
endmodule

// File: rtl/rip_regfile.sv
// Register file with write-before-read behaviour inside one cycle.
// Register 0 always reads as zero. Two combinational read ports.
module rip_regfile
    import rip_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [RA_W-1:0] wa,
    input  logic [XLEN-1:0] wd,
    input  logic [RA_W-1:0] ra0,
    input  logic [RA_W-1:0] ra1,
    output logic [XLEN-1:0] rd0,
    output logic [XLEN-1:0] rd1
);
    logic [XLEN-1:0] mem_q [NREG];

    // Storage update, cleared on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
        end else if (we && (wa != '0)) begin
            mem_q[wa] <= wd;
        end
    end

    // Read ports see the same-cycle write first
    always_comb begin
        if (ra0 == '0)                rd0 = '0;
        else if (we && (wa == ra0))   rd0 = wd;
        else                          rd0 = mem_q[ra0];
        if (ra1 == '0)                rd1 = '0;
        else if (we && (wa == ra1))   rd1 = wd;
        else                          rd1 = mem_q[ra1];
    end
endmodule

// File: rtl/raw_interlock_pipe.sv
// Five-stage in-order pipeline without forwarding, protected by a stall
// interlock. Assumes combinational instruction and data memories outside
// the block; loads and stores both act in the memory stage.
module raw_interlock_pipe
    import rip_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int PC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [PC_W-1:0]   imem_addr,
    input  logic [INSN_W-1:0] imem_data,
    output logic [XLEN-1:0]   dmem_addr,
    output logic [XLEN-1:0]   dmem_wdata,
    output logic              dmem_we,
    input  logic [XLEN-1:0]   dmem_rdata,
    output logic              wb_valid,
    output logic [RA_W-1:0]   wb_dest,
    output logic [XLEN-1:0]   wb_data,
    output logic              stall
);
    localparam int NSRC  = 2;
    localparam int NPROD = 2;

    // Fetch
    logic [PC_W-1:0]   pc_q;
    logic [INSN_W-1:0] fd_insn_q;

    // Decode
    dec_t              dec;
    logic [XLEN-1:0]   rs_val, rt_val, imm_ext;

    // Decode/execute latch
    ex_ctl_t           dx_ex_q;
    mem_ctl_t          dx_mem_q;
    wb_ctl_t           dx_wb_q;
    logic [XLEN-1:0]   dx_a_q, dx_b_q, dx_imm_q;
    logic [RA_W-1:0]   dx_rd_q;
    logic              dx_rf_we, dx_mem_we;

    // Execute/memory latch
    mem_ctl_t          xm_mem_q;
    wb_ctl_t           xm_wb_q;
    logic [XLEN-1:0]   xm_res_q, xm_sd_q;
    logic [RA_W-1:0]   xm_rd_q;
    logic [XLEN-1:0]   alu_res;

    // Memory/writeback latch
    wb_ctl_t           mw_wb_q;
    logic [XLEN-1:0]   mw_res_q;
    logic [RA_W-1:0]   mw_rd_q;
    logic [XLEN-1:0]   mem_res;

    // Hazard inputs
    logic [RA_W-1:0]   src_idx  [NSRC];
    logic              src_used [NSRC];
    logic [RA_W-1:0]   prod_idx [NPROD];
    logic              prod_we  [NPROD];

    // Program counter advances unless decode is held
    always_ff @(posedge clk) begin
        if (!rst_n)      pc_q <= '0;
        else if (!stall) pc_q <= pc_q + 1'b1;
    end

    // Fetch/decode latch holds its instruction during a stall
    always_ff @(posedge clk) begin
        if (!rst_n)      fd_insn_q <= '0;
        else if (!stall) fd_insn_q <= imem_data;
    end

    assign imem_addr = pc_q;

    rip_decode u_decode (
        .insn (fd_insn_q),
        .dec  (dec)
    );

    rip_regfile #(.XLEN(XLEN)) u_regfile (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mw_wb_q.rf_we),
        .wa    (mw_rd_q),
        .wd    (mw_res_q),
        .ra0   (dec.rs),
        .ra1   (dec.rt),
        .rd0   (rs_val),
        .rd1   (rt_val)
    );

    assign imm_ext = {{(XLEN-IMM_W){dec.imm[IMM_W-1]}}, dec.imm};

    // Route decode operands and older producers into the comparator
    always_comb begin
        src_idx[0]  = dec.rs;
        src_idx[1]  = dec.rt;
        src_used[0] = dec.rs_used;
        src_used[1] = dec.rt_used;
        prod_idx[0] = dx_rd_q;
        prod_idx[1] = xm_rd_q;
        prod_we[0]  = dx_rf_we;
        prod_we[1]  = xm_wb_q.rf_we;
    end

    rip_hazard #(.NSRC(NSRC), .NPROD(NPROD)) u_hazard (
        .src_idx  (src_idx),
        .src_used (src_used),
        .prod_idx (prod_idx),
        .prod_we  (prod_we),
        .stall    (stall)
    );

    // Decode/execute latch: loads decode output or an empty slot on stall
    always_ff @(posedge clk) begin
        if (!rst_n || stall) begin
            dx_ex_q  <= '0;
            dx_mem_q <= '0;
            dx_wb_q  <= '0;
            dx_a_q   <= '0;
            dx_b_q   <= '0;
            dx_imm_q <= '0;
            dx_rd_q  <= '0;
        end else begin
            dx_ex_q  <= dec.ex;
            dx_mem_q <= dec.mem;
            dx_wb_q  <= dec.wb;
            dx_a_q   <= rs_val;
            dx_b_q   <= rt_val;
            dx_imm_q <= imm_ext;
            dx_rd_q  <= dec.rd;
        end
    end

    assign dx_rf_we  = dx_wb_q.rf_we;
    assign dx_mem_we = dx_mem_q.wr_en;

    // Execute adder: register or immediate second operand
    assign alu_res = dx_a_q + (dx_ex_q.use_imm ? dx_imm_q : dx_b_q);

    // Execute/memory latch drops execute control
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xm_mem_q <= '0;
            xm_wb_q  <= '0;
            xm_res_q <= '0;
            xm_sd_q  <= '0;
            xm_rd_q  <= '0;
        end else begin
            xm_mem_q <= dx_mem_q;
            xm_wb_q  <= dx_wb_q;
            xm_res_q <= alu_res;
            xm_sd_q  <= dx_b_q;
            xm_rd_q  <= dx_rd_q;
        end
    end

    assign dmem_addr  = xm_res_q;
    assign dmem_wdata = xm_sd_q;
    assign dmem_we    = xm_mem_q.wr_en;
    assign mem_res    = xm_mem_q.rd_en ? dmem_rdata : xm_res_q;

    // Memory/writeback latch keeps only writeback control
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mw_wb_q  <= '0;
            mw_res_q <= '0;
            mw_rd_q  <= '0;
        end else begin
            mw_wb_q  <= xm_wb_q;
            mw_res_q <= mem_res;
            mw_rd_q  <= xm_rd_q;
        end
    end

    assign wb_valid = mw_wb_q.rf_we;
    assign wb_dest  = mw_rd_q;
    assign wb_data  = mw_res_q;
endmodule

// File: rtl/rip_checker.sv
// Temporal checks on the interlocked pipeline, attached by bind.
module rip_checker
    import rip_pkg::*;
#(
    parameter int PC_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            stall,
    input logic [PC_W-1:0] imem_addr,
    input logic            wb_valid,
    input logic [RA_W-1:0] wb_dest,
    input logic            dmem_we,
    input logic            dx_rf_we,
    input logic            dx_mem_we
);
    // R7
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (imem_addr == $past(imem_addr)));

    // R7
    bubble_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (!dx_rf_we && !dx_mem_we));

    // R10
    stall_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && $past(stall)) |=> !stall);

    // R5
    no_zero_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (wb_dest != '0));

    // R11
    wb_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> $past(dx_rf_we, 2));

    // R11
    store_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> $past(dx_mem_we));
endmodule

bind raw_interlock_pipe rip_checker #(.PC_W(PC_W)) u_rip_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .stall     (stall),
    .imem_addr (imem_addr),
    .wb_valid  (wb_valid),
    .wb_dest   (wb_dest),
    .dmem_we   (dmem_we),
    .dx_rf_we  (dx_rf_we),
    .dx_mem_we (dx_mem_we)
);

// File: tb/test_raw_interlock_pipe.sv
module test_raw_interlock_pipe;
    localparam int XLEN = 32;
    localparam int PC_W = 8;
    localparam int MAXC = 256;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] imem_addr;
    logic [31:0]     imem_data;
    logic [XLEN-1:0] dmem_addr, dmem_wdata, dmem_rdata;
    logic            dmem_we;
    logic            wb_valid;
    logic [3:0]      wb_dest;
    logic [XLEN-1:0] wb_data;
    logic            stall;

    logic [31:0] prog [64];
    logic [31:0] bmem [64];

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    // expected per-cycle schedule
    bit          e_stall [MAXC];
    bit          e_wbv   [MAXC];
    int          e_wbd   [MAXC];
    logic [31:0] e_wbdat [MAXC];
    bit          e_mwe   [MAXC];
    logic [31:0] e_maddr [MAXC];
    logic [31:0] e_mdat  [MAXC];
    logic [31:0] m_reg   [16];
    logic [31:0] o_reg   [16];

    always #10 clk = ~clk;

    assign imem_data  = (imem_addr < 64) ? prog[imem_addr[5:0]] : 32'h0;
    assign dmem_rdata = bmem[dmem_addr[5:0]];

    always @(posedge clk) if (dmem_we) bmem[dmem_addr[5:0]] <= dmem_wdata;

    raw_interlock_pipe #(.XLEN(XLEN), .PC_W(PC_W)) i_raw_interlock_pipe (
        .clk(clk), .rst_n(rst_n),
        .imem_addr(imem_addr), .imem_data(imem_data),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
        .dmem_rdata(dmem_rdata),
        .wb_valid(wb_valid), .wb_dest(wb_dest), .wb_data(wb_data),
        .stall(stall)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_chk  = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: got %0d cycles expected under 20000", cyc);
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc(int op, int rd, int rs, int rt, int imm);
        enc = {op[3:0], rd[3:0], rs[3:0], rt[3:0], imm[15:0]};
    endfunction

    function automatic int imax(int a, int b);
        imax = (a > b) ? a : b;
    endfunction

    // Builds the expected schedule and runs one program
    task automatic run_prog(input int n, input string tag);
        int d [64];
        int lastw [16];
        logic [31:0] mm [64];
        int exp_bub = 0;
        int got_bub = 0;
        int endc;
        for (int c = 0; c < MAXC; c++) begin
            e_stall[c] = 0; e_wbv[c] = 0; e_mwe[c] = 0;
            e_wbd[c] = 0; e_wbdat[c] = 0; e_maddr[c] = 0; e_mdat[c] = 0;
        end
        for (int r = 0; r < 16; r++) begin
            lastw[r] = -1; m_reg[r] = 0; o_reg[r] = 0;
        end
        for (int a = 0; a < 64; a++) begin
            mm[a] = 32'(a * 3 + 1);
            bmem[a] = 32'(a * 3 + 1);
        end
        for (int i = 0; i < n; i++) begin
            int op = int'(prog[i][31:28]);
            int rd = int'(prog[i][27:24]);
            int rs = int'(prog[i][23:20]);
            int rt = int'(prog[i][19:16]);
            logic [31:0] imm = {{16{prog[i][15]}}, prog[i][15:0]};
            bit us = (op >= 1 && op <= 4);
            bit ut = (op == 1 || op == 4);
            int prev = (i == 0) ? 0 : d[i-1];
            int di = prev + 1;
            logic [31:0] val = 0;
            logic [31:0] ad;
            if (us && rs != 0 && lastw[rs] >= 0) di = imax(di, d[lastw[rs]] + 3);
            if (ut && rt != 0 && lastw[rt] >= 0) di = imax(di, d[lastw[rt]] + 3);
            d[i] = di;
            for (int c = prev + 1; c < di; c++) begin
                e_stall[c] = 1; exp_bub++;
            end
            ad = m_reg[rs] + imm;
            case (op)
                1: val = m_reg[rs] + m_reg[rt];
                2: val = ad;
                3: val = mm[ad[5:0]];
                4: begin
                    mm[ad[5:0]] = m_reg[rt];
                    e_mwe[di+2] = 1; e_maddr[di+2] = ad; e_mdat[di+2] = m_reg[rt];
                end
                default: ;
            endcase
            if (op >= 1 && op <= 3 && rd != 0) begin
                m_reg[rd] = val; lastw[rd] = i;
                e_wbv[di+3] = 1; e_wbd[di+3] = rd; e_wbdat[di+3] = val;
            end
        end
        endc = d[n-1] + 5;
        // R1: reset state
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(imem_addr == 0 && !stall && !wb_valid && !dmem_we, "R1", "reset outputs",
            {imem_addr, stall, wb_valid, dmem_we}, 0);
        rst_n = 1'b1;
        for (int c = 1; c <= endc; c++) begin
            @(posedge clk);
            @(negedge clk);
            got_bub += int'(stall);
            // R11 timing of every output against the schedule
            chk(stall == e_stall[c], tag, $sformatf("stall c%0d", c), stall, e_stall[c]);
            chk(wb_valid == e_wbv[c], "R11", $sformatf("wb_valid c%0d", c), wb_valid, e_wbv[c]);
            chk(dmem_we == e_mwe[c], "R7", $sformatf("dmem_we c%0d", c), dmem_we, e_mwe[c]);
            if (e_wbv[c] && wb_valid)
                chk(wb_dest == 4'(e_wbd[c]) && wb_data == e_wbdat[c], "R9",
                    $sformatf("wb c%0d", c), {wb_dest, wb_data}, {4'(e_wbd[c]), e_wbdat[c]});
            if (e_mwe[c] && dmem_we)
                chk(dmem_addr == e_maddr[c] && dmem_wdata == e_mdat[c], "R8",
                    $sformatf("store c%0d", c), {dmem_addr, dmem_wdata}, {e_maddr[c], e_mdat[c]});
            if (wb_valid) o_reg[wb_dest] = wb_data;
        end
        chk(got_bub == exp_bub, tag, "bubble count", got_bub, exp_bub);
        for (int r = 0; r < 16; r++)
            chk(o_reg[r] == m_reg[r], "R9", $sformatf("final r%0d", r), o_reg[r], m_reg[r]);
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 64; i++) prog[i] = 32'h0;
    endtask

    initial begin
        // R2: consumer directly behind producer, then load using result
        clear_prog();
        prog[0] = enc(2, 1, 0, 0, 5);
        prog[1] = enc(1, 2, 1, 1, 0);
        prog[2] = enc(3, 3, 2, 0, 0);
        run_prog(3, "R2");

        // R3: one independent instruction in between
        clear_prog();
        prog[0] = enc(2, 1, 0, 0, 7);
        prog[1] = enc(2, 5, 0, 0, 2);
        prog[2] = enc(1, 2, 1, 0, 0);
        run_prog(3, "R3");

        // R4: producer in writeback when consumer decodes
        clear_prog();
        prog[0] = enc(2, 1, 0, 0, 9);
        prog[1] = enc(0, 0, 0, 0, 0);
        prog[2] = enc(0, 0, 0, 0, 0);
        prog[3] = enc(1, 2, 1, 1, 0);
        run_prog(4, "R4");

        // R5: writes to register 0 are dropped and never stall readers
        clear_prog();
        prog[0] = enc(2, 0, 0, 0, 9);
        prog[1] = enc(1, 2, 0, 0, 0);
        prog[2] = enc(2, 3, 2, 0, 4);
        run_prog(3, "R5");

        // R6: rt field of add-immediate and load ignored
        clear_prog();
        prog[0] = enc(2, 1, 0, 0, 3);
        prog[1] = enc(2, 2, 0, 1, 1);
        prog[2] = enc(3, 3, 0, 1, 6);
        run_prog(3, "R6");

        // R8: store then load to same address, no stall
        clear_prog();
        prog[0] = enc(2, 1, 0, 0, 20);
        prog[1] = enc(2, 2, 0, 0, 55);
        prog[2] = enc(0, 0, 0, 0, 0);
        prog[3] = enc(0, 0, 0, 0, 0);
        prog[4] = enc(4, 0, 1, 2, 0);
        prog[5] = enc(3, 3, 1, 0, 0);
        prog[6] = enc(1, 4, 3, 3, 0);
        run_prog(7, "R8");

        // R10: both operands conflict, then a store stalled on rt
        clear_prog();
        prog[0] = enc(2, 1, 0, 0, 1);
        prog[1] = enc(2, 2, 0, 0, 2);
        prog[2] = enc(1, 3, 1, 2, 0);
        prog[3] = enc(4, 0, 1, 3, 4);
        prog[4] = enc(3, 6, 1, 0, 4);
        prog[5] = enc(1, 7, 6, 2, 0);
        run_prog(6, "R10");

        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule